// File: doc/BRIEF.md
# Flag-Composed 16-bit Arithmetic Logic Unit

This block is a 16-bit arithmetic logic unit with no opcode decoder. Its six control bits act as independent pre- and post-processing steps: each operand can be forced to zero and then bitwise inverted. A function bit picks either the bitwise AND or the wrapping sum of the two conditioned operands, and both are computed all the time. A final bit can invert the chosen word. Combining these steps yields constants, negations, increments, decrements, sums, differences, AND and OR.

Two status bits describe the final word. The zero flag is built by OR-reducing each 8-bit half on its own and then combining the halves. The negative flag is the top bit of the word. The result and both flags are registered. A new operation issues every cycle, and its outputs appear one clock edge after its inputs are sampled.

Top module: `alu_flag16`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, `res_o`, `zr_o` and `ng_o` all become 0 at that edge.
- R2: Outputs are registered: the values sampled at one rising edge appear on the outputs just after that edge and stay unchanged until the next edge.
- R3: Control bit order is `ctl_i[5]` zero X, `[4]` invert X, `[3]` zero Y, `[2]` invert Y, `[1]` function, `[0]` invert output. Zeroing is applied before inversion, so code 110000 yields Y.
- R4: With `ctl_i[1]`=1, the block outputs the sum of the conditioned operands modulo 2^16. There is no carry or overflow output.
- R5: With `ctl_i[1]`=0, the block outputs the bitwise AND of the conditioned operands.
- R6: `ctl_i[0]`=1 bitwise-inverts the selected word, so code 000001 yields NOT(X AND Y).
- R7: `zr_o` is 1 exactly when the registered result is 0x0000. A nonzero bit in only one 8-bit half must clear it.
- R8: `ng_o` equals bit 15 of the registered result.
- R9: Codes 101010, 111111 and 111010 give the constants 0, 1 and -1. Codes 001100, 001101 and 001111 give X, NOT X and -X.
- R10: Codes 011111 and 001110 give X+1 and X-1. Codes 000010 and 010011 give X+Y and X-Y. Codes 000000 and 010101 give X AND Y and X OR Y.
- R11: A sum that exceeds 0xFFFF wraps, so 0xFFFF plus 1 gives 0x0000 with `zr_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| x_i | input | 16 | First operand |
| y_i | input | 16 | Second operand |
| ctl_i | input | 6 | Control bits: zero X, invert X, zero Y, invert Y, function, invert output |
| res_o | output | 16 | Registered result |
| zr_o | output | 1 | Registered flag: result is zero |
| ng_o | output | 1 | Registered flag: result is negative |

## Verification
Every named code is run against a reference built from its arithmetic meaning rather than from the flag steps. The operands are edge words (0, 1, 0x7FFF, 0x8000, 0xFFFF) and random pairs. A design that inverts before zeroing gives 0 instead of Y for code 110000. A design that keeps a carry gives a wrong word or a wrong zero flag for 0xFFFF plus 1. The zero flag is driven with results that have bits set in only the upper or only the lower half; a design that reduces only one half would report zero for one of them. The bench also checks that outputs hold until the next edge and that reset clears them in the middle of a run.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  // Control word, MSB first: zero X, invert X, zero Y, invert Y, function, invert out
  typedef struct packed {
    logic clr_a;
    logic inv_a;
    logic clr_b;
    logic inv_b;
    logic use_sum;
    logic inv_out;
  } alu_ctl_t;

  localparam int CTL_W = $bits(alu_ctl_t);

endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  input  logic         clr,
  input  logic         inv,
  output logic [W-1:0] dout
);

  logic [W-1:0] cleared;

  // clear first, then invert
  always_comb begin
    cleared = clr ? '0 : din;
    dout    = inv ? ~cleared : cleared;
  end

endmodule

// File: rtl/alu_func_unit.sv
module alu_func_unit #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         use_sum,
  input  logic         inv_out,
  output logic [W-1:0] word
);

  logic [W-1:0] and_w;
  logic [W-1:0] sum_w;
  logic [W-1:0] pick_w;

  // both paths always evaluated; sum drops its carry (modulo 2^W)
  always_comb begin
    and_w  = a & b;
    sum_w  = a + b;
    pick_w = use_sum ? sum_w : and_w;
    word   = inv_out ? ~pick_w : pick_w;
  end

endmodule

// File: rtl/alu_status.sv
module alu_status #(
  parameter int W     = 16,
  parameter int SEG_W = 8
) (
  input  logic [W-1:0] word,
  output logic         is_zero,
  output logic         is_neg
);

  localparam int NSEG = W / SEG_W;

  logic [NSEG-1:0] seg_any;

  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : g_seg
      assign seg_any[g] = |word[g*SEG_W +: SEG_W];
    end
  endgenerate

  assign is_zero = ~|seg_any;
  assign is_neg  = word[W-1];

endmodule

// File: rtl/alu_flag16.sv
module alu_flag16
  import alu_flag_pkg::*;
#(
  parameter int W     = 16,
  parameter int SEG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [W-1:0]     x_i,
  input  logic [W-1:0]     y_i,
  input  logic [CTL_W-1:0] ctl_i,
  output logic [W-1:0]     res_o,
  output logic             zr_o,
  output logic             ng_o
);

  alu_ctl_t     ctl;
  logic [W-1:0] a_c;
  logic [W-1:0] b_c;
  logic [W-1:0] word;
  logic         zero_c;
  logic         neg_c;

  assign ctl = alu_ctl_t'(ctl_i);

  alu_operand_cond #(.W(W)) u_cond_x (
    .din (x_i), .clr (ctl.clr_a), .inv (ctl.inv_a), .dout (a_c)
  );

  alu_operand_cond #(.W(W)) u_cond_y (
    .din (y_i), .clr (ctl.clr_b), .inv (ctl.inv_b), .dout (b_c)
  );

  alu_func_unit #(.W(W)) u_func (
    .a (a_c), .b (b_c), .use_sum (ctl.use_sum), .inv_out (ctl.inv_out), .word (word)
  );

  alu_status #(.W(W), .SEG_W(SEG_W)) u_stat (
    .word (word), .is_zero (zero_c), .is_neg (neg_c)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      res_o <= '0;
      zr_o  <= 1'b0;
      ng_o  <= 1'b0;
    end else begin
      res_o <= word;
      zr_o  <= zero_c;
      ng_o  <= neg_c;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    $past(rst_i) |-> (res_o == '0 && !zr_o && !ng_o)); // R1

  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (zr_o == (res_o == '0))); // R7

  AST_NEG_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (ng_o == res_o[W-1])); // R8

  AST_CONST_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(ctl_i) == 6'b101010) |-> (res_o == '0)); // R9

  AST_PASS_X: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(ctl_i) == 6'b001100) |-> (res_o == $past(x_i))); // R9

  AST_NAND_OUT: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(ctl_i) == 6'b000001)
      |-> (res_o == ~($past(x_i) & $past(y_i)))); // R6

endmodule

// File: tb/alu_flag16_tb.sv
`timescale 1ns/1ps
module alu_flag16_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] x, y;
  logic [5:0]  ctl;
  logic [15:0] res;
  logic        zr, ng;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  alu_flag16 dut_i (
    .clk_i (clk), .rst_i (rst), .x_i (x), .y_i (y), .ctl_i (ctl),
    .res_o (res), .zr_o (zr), .ng_o (ng)
  );

  localparam int NOPS = 12;
  localparam logic [5:0] CODES [NOPS] = '{
    6'b101010, 6'b111111, 6'b111010, 6'b001100, 6'b001101, 6'b001111,
    6'b011111, 6'b001110, 6'b000010, 6'b010011, 6'b000000, 6'b010101
  };
  localparam int NEDGE = 5;
  localparam logic [15:0] EDGES [NEDGE] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};

  function automatic logic [15:0] ref_op(int k, logic [15:0] a, logic [15:0] b);
    case (k)
      0:  return 16'h0000;
      1:  return 16'h0001;
      2:  return 16'hFFFF;
      3:  return a;
      4:  return ~a;
      5:  return 16'h0000 - a;
      6:  return a + 16'h0001;
      7:  return a - 16'h0001;
      8:  return a + b;
      9:  return a - b;
      10: return a & b;
      default: return a | b;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_op(logic [5:0] c, logic [15:0] a, logic [15:0] b);
    @(negedge clk);
    ctl = c; x = a; y = b;
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst = 1'b1; x = '0; y = '0; ctl = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 res", res, 16'h0);
    check("R1 zr", {15'h0, zr}, 16'h0);
    check("R1 ng", {15'h0, ng}, 16'h0);
    rst = 1'b0;

    // R9 R10 table walk over edge and random operands
    for (int k = 0; k < NOPS; k++) begin
      for (int p = 0; p < NEDGE * NEDGE + 8; p++) begin
        logic [15:0] a, b, e;
        if (p < NEDGE * NEDGE) begin
          a = EDGES[p / NEDGE]; b = EDGES[p % NEDGE];
        end else begin
          a = 16'($urandom); b = 16'($urandom);
        end
        run_op(CODES[k], a, b);
        e = ref_op(k, a, b);
        check(k < 6 ? "R9 result" : "R10 result", res, e);
        check("R7 zero flag", {15'h0, zr}, {15'h0, e == 16'h0});
        check("R8 neg flag", {15'h0, ng}, {15'h0, e[15]});
      end
    end

    // R3 zero before invert
    run_op(6'b110000, 16'h1234, 16'hA5C3);
    check("R3 clear-then-invert X", res, 16'hA5C3);
    run_op(6'b001100, 16'h5A0F, 16'hFFFF);
    check("R3 Y path cleared+inverted", res, 16'h5A0F);
    // R4 sum, R5 and
    run_op(6'b000010, 16'h1234, 16'h4321);
    check("R4 sum", res, 16'h5555);
    run_op(6'b000000, 16'hF0F0, 16'h3C3C);
    check("R5 and", res, 16'h3030);
    // R6 inverted output
    run_op(6'b000001, 16'hF0F0, 16'h3C3C);
    check("R6 nand", res, 16'hCFCF);
    // R7 only one half nonzero
    run_op(6'b001100, 16'h0100, 16'h0);
    check("R7 upper half", {15'h0, zr}, 16'h0);
    run_op(6'b001100, 16'h0001, 16'h0);
    check("R7 lower half", {15'h0, zr}, 16'h0);
    // R8 sign bit
    run_op(6'b001100, 16'h8000, 16'h0);
    check("R8 neg", {15'h0, ng}, 16'h1);
    // R11 wrap
    run_op(6'b000010, 16'hFFFF, 16'h0001);
    check("R11 wrap result", res, 16'h0000);
    check("R11 wrap zero", {15'h0, zr}, 16'h1);

    // R2 output holds until the next edge
    run_op(6'b001100, 16'h1111, 16'h0);
    @(negedge clk);
    x = 16'h2222;
    #5;
    check("R2 hold before edge", res, 16'h1111);
    @(negedge clk);
    check("R2 update after edge", res, 16'h2222);

    // R1 reset mid-run
    x = 16'h8001; ctl = 6'b001100;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run res", res, 16'h0);
    check("R1 mid-run ng", {15'h0, ng}, 16'h0);
    rst = 1'b0;

    finish_up();
  end

endmodule